// File: doc/BRIEF.md
# Sparse Byte-Lane Frame Packer

This block assembles a frame of bytes from eight parallel byte lanes. Each lane has its own enable bit, and any subset of the lanes may be enabled in any cycle, including subsets with gaps. A start pulse opens a frame. From that cycle on, every enabled byte is squeezed into a dense byte stream in a 64-byte buffer, with no holes left by the disabled lanes. An end pulse closes the frame. One cycle later the block presents the whole buffer as one 512-bit word, together with the number of bytes collected and a flag that says whether bytes were dropped.

Upstream logic uses it to turn bursts of sparse byte traffic into a single packed word for a wide consumer. Only one frame is open at a time. The buffer is the output register, so the packed word stays readable until the next frame opens.

Top module: `byte_gather_packer`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `dout`, `dout_count`, `dout_valid` and `dout_overflow` are all zero.
- R2: Lane i is carried on `lane_data[8i+7:8i]` and qualified by `lane_en[i]`. Packed byte j appears on `dout[8j+7:8j]`. Within one cycle, the enabled bytes are stored at consecutive positions in ascending lane order, and disabled lanes leave no gap.
- R3: The bytes taken in a cycle follow all bytes from earlier cycles of the same frame. `dout_count` rises by the number of set bits in `lane_en` on every capturing cycle that does not reach the capacity limit.
- R4: When `frame_start` is seen with no frame open, the buffer and count are cleared and that cycle's enabled bytes become the first bytes of the frame. When `frame_start` is seen while a frame is open, it is ignored and the frame continues.
- R5: When `frame_end` is seen during an open frame, that cycle's bytes are included. On the next cycle `dout_valid` is high for exactly one cycle, while `dout` and `dout_count` show the finished frame. A frame may open and close in the same cycle.
- R6: Byte positions at or above `dout_count` read as zero.
- R7: The buffer holds 64 bytes. Bytes that arrive after it is full are dropped, and the lowest lanes are kept first when only part of a cycle fits. Any drop sets `dout_overflow`, which reads 1 together with `dout_valid` and a count of 64. Filling the buffer exactly to 64 bytes is not an overflow.
- R8: With no frame open, lane data, enables and `frame_end` have no effect: `dout_valid` stays low and `dout` and `dout_count` do not change.
- R9: After a frame closes, `dout`, `dout_count` and `dout_overflow` hold their values until the next frame opens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_data | input | 64 | Eight byte lanes, lane i at bits 8i+7:8i |
| lane_en | input | 8 | Per-lane byte enable |
| frame_start | input | 1 | Opens a frame |
| frame_end | input | 1 | Closes the open frame |
| dout | output | 512 | Packed frame, byte j at bits 8j+7:8j |
| dout_valid | output | 1 | One-cycle pulse after the frame closes |
| dout_count | output | 7 | Number of bytes in the frame, 0 to 64 |
| dout_overflow | output | 1 | Bytes of this frame were dropped |

## Verification
The bench sweeps all 256 enable patterns, each inside a three-cycle frame that also uses the complement pattern and a scrambled pattern. This targets a compactor that computes a lane's slot from the wrong prefix, which would leave holes or swap bytes. The bench also targets a write pointer that advances by the wrong amount, which would overwrite earlier cycles. Capacity edges get their own cases: an exact 64-byte fill that must not flag, and a cycle that only partly fits, where a design that keeps the wrong lanes or still counts past 64 shows up in `dout`. Further cases cover a start pulse inside an open frame, an end pulse with no frame open, and a frame that opens and closes in one cycle. These catch control that restarts the frame, emits stray valid pulses, or misses the bytes of the boundary cycles.

// File: rtl/byte_pack_pkg.sv
package byte_pack_pkg;

    localparam int LANES     = 8;
    localparam int BYTE_W    = 8;
    localparam int BUF_BYTES = 64;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_CAPTURE = 1'b1
    } frame_state_e;

    // Per-cycle control decided by the frame sequencer
    typedef struct packed {
        logic capture;  // this cycle's bytes belong to a frame
        logic clear;    // this cycle opens a new frame
        logic close;    // this cycle closes the frame
    } frame_ctl_t;

endpackage

// File: rtl/lane_compactor.sv
module lane_compactor
    import byte_pack_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int B_W     = BYTE_W,
    localparam int SLOT_W = $clog2(N_LANES + 1)
) (
    input  logic [N_LANES*B_W-1:0] lane_data,
    input  logic [N_LANES-1:0]     lane_en,
    output logic [N_LANES*B_W-1:0] slot_data,
    output logic [SLOT_W-1:0]      slot_count
);

    logic [N_LANES-1:0][SLOT_W-1:0] lane_slot;

    // Slot of each lane = number of enabled lanes below it
    always_comb begin
        logic [SLOT_W-1:0] run;
        run = '0;
        for (int i = 0; i < N_LANES; i++) begin
            lane_slot[i] = run;
            run = run + SLOT_W'(lane_en[i]);
        end
        slot_count = run;
    end

    for (genvar k = 0; k < N_LANES; k++) begin : g_slot
        always_comb begin
            slot_data[k*B_W +: B_W] = '0;
            for (int i = 0; i < N_LANES; i++) begin
                if (lane_en[i] && (lane_slot[i] == SLOT_W'(k))) begin
                    slot_data[k*B_W +: B_W] = slot_data[k*B_W +: B_W] | lane_data[i*B_W +: B_W];
                end
            end
        end
    end

endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
    import byte_pack_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    input  logic       frame_end,
    output frame_ctl_t ctl,
    output logic       done_q
);

    frame_state_e state_q;

    always_comb begin
        ctl.capture = (state_q == ST_CAPTURE) || frame_start;
        ctl.clear   = (state_q == ST_IDLE) && frame_start;
        ctl.close   = ctl.capture && frame_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            done_q <= ctl.close;
            if (ctl.close) begin
                state_q <= ST_IDLE;
            end else if (ctl.clear) begin
                state_q <= ST_CAPTURE;
            end
        end
    end

    AST_VALID_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(frame_end)); // R5

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CAPTURE && frame_start && !frame_end) |=> (state_q == ST_CAPTURE)); // R4

endmodule

// File: rtl/pack_buffer.sv
module pack_buffer
    import byte_pack_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int B_W     = BYTE_W,
    parameter int DEPTH   = BUF_BYTES,
    localparam int SLOT_W = $clog2(N_LANES + 1),
    localparam int PTR_W  = $clog2(DEPTH + N_LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  frame_ctl_t             ctl,
    input  logic [N_LANES*B_W-1:0] slot_data,
    input  logic [SLOT_W-1:0]      slot_count,
    output logic [DEPTH*B_W-1:0]   buf_bytes,
    output logic [PTR_W-1:0]       wr_ptr,
    output logic                   ovf
);

    logic [PTR_W-1:0]     base;
    logic [PTR_W-1:0]     room;
    logic [PTR_W-1:0]     want;
    logic [PTR_W-1:0]     take;
    logic                 spill;
    logic [DEPTH*B_W-1:0] buf_n;

    always_comb begin
        base  = ctl.clear ? '0 : wr_ptr;
        room  = PTR_W'(DEPTH) - base;
        want  = PTR_W'(slot_count);
        spill = want > room;
        take  = spill ? room : want;
    end

    always_comb begin
        buf_n = ctl.clear ? '0 : buf_bytes;
        if (ctl.capture) begin
            for (int p = 0; p < DEPTH; p++) begin
                for (int k = 0; k < N_LANES; k++) begin
                    if ((PTR_W'(k) < take) && (base + PTR_W'(k) == PTR_W'(p))) begin
                        buf_n[p*B_W +: B_W] = slot_data[k*B_W +: B_W];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_bytes <= '0;
            wr_ptr    <= '0;
            ovf       <= 1'b0;
        end else begin
            buf_bytes <= buf_n;
            if (ctl.capture) begin
                wr_ptr <= base + take;
                ovf    <= (ctl.clear ? 1'b0 : ovf) | spill;
            end
        end
    end

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
        wr_ptr <= PTR_W'(DEPTH)); // R7

    AST_PTR_MONO: assert property (@(posedge clk) disable iff (rst)
        !ctl.clear |=> wr_ptr >= $past(wr_ptr)); // R3

    AST_OVF_FULL: assert property (@(posedge clk) disable iff (rst)
        ovf |-> wr_ptr == PTR_W'(DEPTH)); // R7

endmodule

// File: rtl/byte_gather_packer.sv
module byte_gather_packer
    import byte_pack_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [LANES*BYTE_W-1:0]     lane_data,
    input  logic [LANES-1:0]            lane_en,
    input  logic                        frame_start,
    input  logic                        frame_end,
    output logic [BUF_BYTES*BYTE_W-1:0] dout,
    output logic                        dout_valid,
    output logic [6:0]                  dout_count,
    output logic                        dout_overflow
);

    localparam int SLOT_W = $clog2(LANES + 1);
    localparam int PTR_W  = $clog2(BUF_BYTES + LANES + 1);

    frame_ctl_t                ctl;
    logic [LANES*BYTE_W-1:0]   slot_data;
    logic [SLOT_W-1:0]         slot_count;
    logic [PTR_W-1:0]          wr_ptr;

    frame_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .ctl         (ctl),
        .done_q      (dout_valid)
    );

    lane_compactor #(.N_LANES(LANES), .B_W(BYTE_W)) u_compact (
        .lane_data  (lane_data),
        .lane_en    (lane_en),
        .slot_data  (slot_data),
        .slot_count (slot_count)
    );

    pack_buffer #(.N_LANES(LANES), .B_W(BYTE_W), .DEPTH(BUF_BYTES)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .slot_data  (slot_data),
        .slot_count (slot_count),
        .buf_bytes  (dout),
        .wr_ptr     (wr_ptr),
        .ovf        (dout_overflow)
    );

    assign dout_count = 7'(wr_ptr);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctl.capture |=> ($stable(dout) && $stable(dout_count) && $stable(dout_overflow))); // R8

    AST_OVF_COUNT: assert property (@(posedge clk) disable iff (rst)
        (dout_valid && dout_overflow) |-> dout_count == 7'(BUF_BYTES)); // R7

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        dout_valid |-> !$past(dout_valid) || $past(frame_start)); // R5

endmodule

// File: tb/byte_gather_packer_tb_top.sv
module byte_gather_packer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 64;

    logic         clk = 1'b0;
    logic         rst;
    logic [63:0]  lane_data;
    logic [7:0]   lane_en;
    logic         frame_start;
    logic         frame_end;
    logic [511:0] dout;
    logic         dout_valid;
    logic [6:0]   dout_count;
    logic         dout_overflow;

    int checks   = 0;
    int failures = 0;

    logic [7:0] exp_mem [NB];
    int         exp_cnt;
    bit         exp_ovf;
    bit         exp_cap;
    bit         exp_valid;

    byte_gather_packer dut_i (
        .clk           (clk),
        .rst           (rst),
        .lane_data     (lane_data),
        .lane_en       (lane_en),
        .frame_start   (frame_start),
        .frame_end     (frame_end),
        .dout          (dout),
        .dout_valid    (dout_valid),
        .dout_count    (dout_count),
        .dout_overflow (dout_overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input string req, input logic [511:0] act, input logic [511:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [511:0] exp_vec();
        logic [511:0] v = '0;
        for (int j = 0; j < NB; j++) v[j*8 +: 8] = exp_mem[j];
        return v;
    endfunction

    task automatic step(input logic [63:0] d, input logic [7:0] e,
                        input bit s, input bit f, input string req);
        @(negedge clk);
        lane_data   = d;
        lane_en     = e;
        frame_start = s;
        frame_end   = f;
        @(posedge clk);
        #1;
        exp_valid = 1'b0;
        if (!exp_cap && s) begin
            exp_cap = 1'b1;
            exp_cnt = 0;
            exp_ovf = 1'b0;
            for (int j = 0; j < NB; j++) exp_mem[j] = 8'h00;
        end
        if (exp_cap) begin
            for (int i = 0; i < 8; i++) begin
                if (e[i]) begin
                    if (exp_cnt < NB) begin
                        exp_mem[exp_cnt] = d[i*8 +: 8];
                        exp_cnt++;
                    end else begin
                        exp_ovf = 1'b1;
                    end
                end
            end
            if (f) begin
                exp_cap   = 1'b0;
                exp_valid = 1'b1;
            end
        end
        chk({req, " valid (R5)"}, 512'(dout_valid), 512'(exp_valid));
        chk({req, " count (R3)"}, 512'(dout_count), 512'(exp_cnt));
        chk({req, " data (R2)"}, dout, exp_vec());
        if (exp_valid) chk({req, " overflow (R7)"}, 512'(dout_overflow), 512'(exp_ovf));
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        rst = 1'b1; lane_data = '0; lane_en = '0; frame_start = 0; frame_end = 0;
        exp_cnt = 0; exp_ovf = 0; exp_cap = 0; exp_valid = 0;
        for (int j = 0; j < NB; j++) exp_mem[j] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset dout", dout, '0);
        chk("R1 reset flags", 512'({dout_valid, dout_overflow, dout_count}), '0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 after reset", 512'({dout_valid, dout_overflow, dout_count}), '0);

        // Sweep of every enable pattern (R2, R3)
        for (int e = 0; e < 256; e++) begin
            step(rnd64(), 8'(e), 1, 0, "R2 sweep a");
            step(rnd64(), ~8'(e), 0, 0, "R3 sweep b");
            step(rnd64(), 8'(e) ^ 8'h5A, 0, 1, "R3 sweep c");
            checks++;
            if ((dout >> (8 * exp_cnt)) !== '0) begin
                failures++;
                $display("FAIL R6 upper bytes actual=%h expected=0", dout >> (8 * exp_cnt));
            end
            step(rnd64(), $urandom, 0, 0, "R8 idle");
        end

        // Start inside an open frame is ignored (R4)
        step(rnd64(), 8'h0F, 1, 0, "R4 open");
        step(rnd64(), 8'hF0, 1, 0, "R4 restart ignored");
        step(rnd64(), 8'h81, 0, 1, "R4 close");

        // Single-cycle frame (R5)
        step(rnd64(), 8'hA5, 1, 1, "R5 one-cycle");
        step(rnd64(), 8'hFF, 0, 0, "R9 hold");

        // End with no frame open (R8)
        step(rnd64(), 8'hFF, 0, 1, "R8 stray end");
        step(rnd64(), 8'h3C, 0, 0, "R9 hold idle");

        // Exact fill is not an overflow (R7)
        step(rnd64(), 8'hFF, 1, 0, "R7 fill");
        for (int c = 0; c < 6; c++) step(rnd64(), 8'hFF, 0, 0, "R7 fill");
        step(rnd64(), 8'hFF, 0, 1, "R7 exact");

        // Partial fit then drop (R7)
        step(rnd64(), 8'hFF, 1, 0, "R7 ovf");
        for (int c = 0; c < 6; c++) step(rnd64(), 8'hFF, 0, 0, "R7 ovf");
        step(rnd64(), 8'hF0, 0, 0, "R7 ovf 60");
        step(rnd64(), 8'hFF, 0, 0, "R7 partial");
        step(rnd64(), 8'hFF, 0, 0, "R7 drop");
        step(rnd64(), 8'h00, 0, 1, "R7 close");
        step(rnd64(), 8'h00, 0, 0, "R9 hold ovf");
        chk("R9 overflow held", 512'(dout_overflow), 512'(1));

        // New frame clears overflow (R4)
        step(rnd64(), 8'h03, 1, 1, "R4 clear");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule